// File: doc/BRIEF.md
# Stack Push/Pop Register-List Sequencer

This block carries out a multi-register stack transfer for a small processor core. It is started by a one-cycle `start_i` pulse. With the pulse come the direction, an 8-bit mask of low registers (R0 to R7) and one extra-register bit. For a store to the stack, the extra register is the link register (index 14). For a load from the stack, the extra register is the program counter. The stack is full-descending: a store first moves the pointer down one word and then writes at the new pointer. A load reads at the current pointer and then moves the pointer up one word.

Each selected register costs exactly one 32-bit memory transfer on a valid/ready bus. Unselected registers cost nothing. Register values are read through a combinational register-file read port. Loaded values return through a write port. The final stack pointer and the next program counter are handed back with a one-cycle `done_o` pulse.

Back-pressure rules for the memory bus:
- `mem_req_o` is the valid signal. Once raised, it stays high, and `mem_addr_o`, `mem_we_o` and `mem_wdata_o` stay unchanged, until `mem_ready_i` is sampled high at a rising edge.
- `mem_ready_i` may be held low for any number of cycles.
- Load data on `mem_rdata_i` is taken in the same cycle in which `mem_ready_i` is high.

Top module: `stk_seq`

## Requirements
- R1: Store direction (`pop_i`=0) transfers the link register first when the extra bit is set. It then transfers the selected low registers from R7 down to R0. Each write goes to the pointer minus 4, and that address becomes the new pointer. The write data is the value the register file returns for the index on `rf_raddr_o`.
- R2: Load direction (`pop_i`=1) transfers the selected low registers from R0 up to R7. When the extra bit is set, the program counter follows last. Each read uses the current pointer, which then rises by 4.
- R3: With `done_o`, `sp_we_o` is high and `sp_o` equals the start pointer, less 4 per transfer for a store or plus 4 per transfer for a load.
- R4: When the program counter is loaded, `pc_o` equals the loaded word with bit 0 cleared, and `branch_o` is high in the `done_o` cycle.
- R5: When the program counter is not loaded, `pc_o` equals `pc_i` plus 2 and `branch_o` stays low.
- R6: The number of accepted bus transfers equals the number of set mask bits plus the extra bit. A register whose bit is clear gets no transfer.
- R7: An empty mask with the extra bit clear raises `done_o` in the cycle after `start_i`, with no request, and `sp_o` equals `sp_i`.
- R8: While `mem_req_o` is high and `mem_ready_i` low, the request, address, direction and write data hold their values into the next cycle.
- R9: `done_o` is high for exactly one cycle, the cycle right after the final accepted transfer. `mem_req_o` is low in that cycle.
- R10: During loads of low registers, `rf_we_o` is high only in a cycle where the transfer is accepted. In that cycle `rf_waddr_o` is the register index and `rf_wdata_o` equals `mem_rdata_i`. Program-counter loads and stores never raise `rf_we_o`.
- R11: After reset, `mem_req_o`, `done_o`, `rf_we_o` and `branch_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle start pulse, taken while idle |
| pop_i | input | 1 | 1 = load from stack, 0 = store to stack |
| list_i | input | 8 | Low-register selection mask, bit n = Rn |
| extra_i | input | 1 | Include link register (store) or program counter (load) |
| sp_i | input | 32 | Stack pointer at start |
| pc_i | input | 32 | Program counter of the instruction |
| mem_req_o | output | 1 | Bus request (valid) |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Word address |
| mem_wdata_o | output | 32 | Write data |
| mem_ready_i | input | 1 | Bus accepts the transfer |
| mem_rdata_i | input | 32 | Read data, valid with ready |
| rf_raddr_o | output | 4 | Register-file read index |
| rf_rdata_i | input | 32 | Register-file read data |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | 4 | Register-file write index |
| rf_wdata_o | output | 32 | Register-file write data |
| done_o | output | 1 | Operation complete pulse |
| sp_we_o | output | 1 | Stack pointer update strobe |
| sp_o | output | 32 | Final stack pointer |
| pc_we_o | output | 1 | Program counter update strobe |
| pc_o | output | 32 | Next program counter |
| branch_o | output | 1 | Program counter was loaded; fetch must redirect |

## Verification
Two things can fall in one cycle: a load of a low register and the writing of its value into the register file. Both are triggered by the same accepted handshake, so a register-file write that is one cycle late or early would be caught. The reference model in the bench compares `rf_we_o`, `rf_waddr_o` and `rf_wdata_o` in every cycle where it has just driven `mem_ready_i` high. It also checks that nothing is written in stalled cycles, which are provoked by a pseudo-random ready pattern. The second case is the final program-counter load followed by `done_o`. Here the bench checks that the redirect and the incremented pointer appear exactly one cycle after the last handshake, under both steady and stalled ready.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } stk_state_e;
endpackage

// File: rtl/stk_pick.sv
// Finds the highest or lowest set bit of a mask, selected at elaboration.
module stk_pick #(
  parameter int N          = 8,
  parameter bit HIGH_FIRST = 1'b0,
  localparam int LW        = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec_i,
  output logic          any_o,
  output logic [LW-1:0] idx_o
);
  assign any_o = |vec_i;

  generate
    if (HIGH_FIRST) begin : g_high
      always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
          if (vec_i[i]) idx_o = LW'(i);
        end
      end
    end else begin : g_low
      always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
          if (vec_i[i]) idx_o = LW'(i);
        end
      end
    end
  endgenerate
endmodule

// File: rtl/stk_ptr.sv
// Stack pointer register and access address generation.
module stk_ptr #(
  parameter int DW   = 32,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [DW-1:0] load_val_i,
  input  logic          step_i,
  input  logic          dir_pop_i,
  output logic [DW-1:0] cur_o,
  output logic [DW-1:0] addr_o
);
  localparam logic [DW-1:0] STEP_V = DW'(STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_o <= '0;
    else if (load_i) cur_o <= load_val_i;
    else if (step_i) cur_o <= dir_pop_i ? cur_o + STEP_V : cur_o - STEP_V;
  end

  // store: pre-decrement; load: use current pointer
  assign addr_o = dir_pop_i ? cur_o : cur_o - STEP_V;

  // R1
  push_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && !dir_pop_i) |=> (cur_o == $past(addr_o)));

  // R2
  pop_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && dir_pop_i) |=> (cur_o == $past(addr_o) + STEP_V));
endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter int DW       = 32,
  parameter int NLOW     = 8,
  parameter int RIW      = 4,
  parameter int LINK_IDX = 14,
  parameter int PC_STEP  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            pop_i,
  input  logic [NLOW-1:0] list_i,
  input  logic            extra_i,
  input  logic [DW-1:0]   sp_i,
  input  logic [DW-1:0]   pc_i,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [DW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  input  logic            mem_ready_i,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic [RIW-1:0]  rf_raddr_o,
  input  logic [DW-1:0]   rf_rdata_i,
  output logic            rf_we_o,
  output logic [RIW-1:0]  rf_waddr_o,
  output logic [DW-1:0]   rf_wdata_o,
  output logic            done_o,
  output logic            sp_we_o,
  output logic [DW-1:0]   sp_o,
  output logic            pc_we_o,
  output logic [DW-1:0]   pc_o,
  output logic            branch_o
);
  localparam int LW   = (NLOW > 1) ? $clog2(NLOW) : 1;
  localparam int STEP = DW / 8;

  stk_state_e      state_q;
  logic [NLOW:0]   pend_q;     // bit NLOW = extra register
  logic            dir_pop_q;
  logic [DW-1:0]   pc_q;
  logic            took_pc_q;

  logic            lo_any, hi_any, low_any;
  logic [LW-1:0]   lo_idx, hi_idx, sel_idx;
  logic            sel_extra;
  logic [NLOW:0]   sel_mask;
  logic            accept;
  logic            start_ok;
  logic [DW-1:0]   sp_cur;

  stk_pick #(.N(NLOW), .HIGH_FIRST(1'b0)) u_pick_lo (
    .vec_i(pend_q[NLOW-1:0]), .any_o(lo_any), .idx_o(lo_idx));

  stk_pick #(.N(NLOW), .HIGH_FIRST(1'b1)) u_pick_hi (
    .vec_i(pend_q[NLOW-1:0]), .any_o(hi_any), .idx_o(hi_idx));

  assign low_any  = dir_pop_q ? lo_any : hi_any;
  assign sel_idx  = dir_pop_q ? lo_idx : hi_idx;
  // store: extra register goes first; load: extra register goes last
  assign sel_extra = dir_pop_q ? (pend_q[NLOW] && !low_any) : pend_q[NLOW];

  always_comb begin
    sel_mask = '0;
    if (sel_extra) sel_mask[NLOW]    = 1'b1;
    else           sel_mask[sel_idx] = 1'b1;
  end

  assign start_ok  = (state_q == ST_IDLE) && start_i;
  assign mem_req_o = (state_q == ST_RUN) && (pend_q != '0);
  assign accept    = mem_req_o && mem_ready_i;

  stk_ptr #(.DW(DW), .STEP(STEP)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (start_ok),
    .load_val_i (sp_i),
    .step_i     (accept),
    .dir_pop_i  (dir_pop_q),
    .cur_o      (sp_cur),
    .addr_o     (mem_addr_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      pend_q    <= '0;
      dir_pop_q <= 1'b0;
      pc_q      <= '0;
      took_pc_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q   <= ST_RUN;
            pend_q    <= {extra_i, list_i};
            dir_pop_q <= pop_i;
            pc_q      <= pc_i;
            took_pc_q <= 1'b0;
          end
        end
        ST_RUN: begin
          if (pend_q == '0) begin
            state_q <= ST_IDLE;
          end else if (accept) begin
            pend_q <= pend_q & ~sel_mask;
            if (dir_pop_q && sel_extra) begin
              pc_q      <= mem_rdata_i & ~DW'(1);
              took_pc_q <= 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_we_o    = !dir_pop_q;
  assign rf_raddr_o  = sel_extra ? RIW'(LINK_IDX) : RIW'(sel_idx);
  assign mem_wdata_o = rf_rdata_i;

  assign rf_we_o    = accept && dir_pop_q && !sel_extra;
  assign rf_waddr_o = RIW'(sel_idx);
  assign rf_wdata_o = mem_rdata_i;

  assign done_o   = (state_q == ST_RUN) && (pend_q == '0);
  assign sp_we_o  = done_o;
  assign sp_o     = sp_cur;
  assign pc_we_o  = done_o;
  assign pc_o     = took_pc_q ? pc_q : pc_q + DW'(PC_STEP);
  assign branch_o = done_o && took_pc_q;

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  done_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !mem_req_o);

  // R4
  branch_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    branch_o |-> (done_o && !pc_o[0]));

  // R10
  rf_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |-> (mem_req_o && mem_ready_i && !mem_we_o));
endmodule

// File: tb/stk_seq_tb.sv
`timescale 1ns/1ps
module stk_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, pop_i = 1'b0, extra_i = 1'b0;
  logic [7:0]  list_i = '0;
  logic [31:0] sp_i = '0, pc_i = '0;
  logic        mem_req_o, mem_we_o, mem_ready_i = 1'b0;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i = '0;
  logic [3:0]  rf_raddr_o, rf_waddr_o;
  logic [31:0] rf_rdata_i, rf_wdata_o;
  logic        rf_we_o, done_o, sp_we_o, pc_we_o, branch_o;
  logic [31:0] sp_o, pc_o;

  logic [31:0] regs [16];
  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  assign rf_rdata_i = regs[rf_raddr_o];

  stk_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pop_i(pop_i), .list_i(list_i),
    .extra_i(extra_i), .sp_i(sp_i), .pc_i(pc_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ready_i(mem_ready_i), .mem_rdata_i(mem_rdata_i),
    .rf_raddr_o(rf_raddr_o), .rf_rdata_i(rf_rdata_i), .rf_we_o(rf_we_o),
    .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o), .done_o(done_o),
    .sp_we_o(sp_we_o), .sp_o(sp_o), .pc_we_o(pc_we_o), .pc_o(pc_o), .branch_o(branch_o));

  function automatic logic [31:0] memval(input logic [31:0] a);
    return (a ^ 32'h5A5A_0000) | 32'h1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  // Runs one operation against a behavioural model of expected transfers.
  task automatic run_op(input bit pop, input logic [7:0] lst, input bit ext,
                        input logic [31:0] sp, input logic [31:0] pc, input bit bp);
    logic [31:0] q_addr[$];
    logic        q_we[$];
    logic [31:0] q_data[$];
    int          q_idx[$];
    logic [31:0] s, exp_pc;
    bit          exp_br, stalled;
    int          n_exp, n_acc, cyc;
    string       tag;
    s = sp; exp_pc = pc + 32'd2; exp_br = 1'b0;
    if (!pop) begin
      if (ext) begin
        s -= 4; q_addr.push_back(s); q_we.push_back(1'b1);
        q_data.push_back(regs[14]); q_idx.push_back(14);
      end
      for (int i = 7; i >= 0; i--) if (lst[i]) begin
        s -= 4; q_addr.push_back(s); q_we.push_back(1'b1);
        q_data.push_back(regs[i]); q_idx.push_back(i);
      end
    end else begin
      for (int i = 0; i < 8; i++) if (lst[i]) begin
        q_addr.push_back(s); q_we.push_back(1'b0);
        q_data.push_back(memval(s)); q_idx.push_back(i); s += 4;
      end
      if (ext) begin
        q_addr.push_back(s); q_we.push_back(1'b0);
        q_data.push_back(memval(s)); q_idx.push_back(15);
        exp_pc = memval(s) & ~32'h1; exp_br = 1'b1; s += 4;
      end
    end
    n_exp = q_addr.size();
    tag = pop ? "R2" : "R1";

    @(negedge clk);
    start_i = 1'b1; pop_i = pop; list_i = lst; extra_i = ext; sp_i = sp; pc_i = pc;
    @(negedge clk);
    start_i = 1'b0; list_i = '0; extra_i = 1'b0;
    n_acc = 0; cyc = 0; stalled = 1'b0;
    while (1) begin
      mem_ready_i = bp ? (($urandom % 3) != 0) : 1'b1;
      mem_rdata_i = memval(mem_addr_o);
      #1;
      if (q_addr.size() == 0) begin
        chk(done_o === 1'b1, (n_exp == 0 && !ext) ? "R7 done" : "R9 done", 32'(done_o), 1);
        chk(mem_req_o === 1'b0, "R9 no req with done", 32'(mem_req_o), 0);
        chk(sp_we_o === 1'b1 && sp_o === s, "R3 sp", sp_o, s);
        chk(pc_we_o === 1'b1 && pc_o === exp_pc, exp_br ? "R4 pc" : "R5 pc", pc_o, exp_pc);
        chk(branch_o === exp_br, exp_br ? "R4 branch" : "R5 branch", 32'(branch_o), 32'(exp_br));
        chk(n_acc == n_exp, "R6 transfer count", n_acc, n_exp);
        break;
      end
      chk(done_o === 1'b0, "R9 early done", 32'(done_o), 0);
      chk(mem_req_o === 1'b1, stalled ? "R8 req hold" : "R6 req", 32'(mem_req_o), 1);
      chk(mem_addr_o === q_addr[0], stalled ? "R8 addr" : {tag, " addr"}, mem_addr_o, q_addr[0]);
      chk(mem_we_o === q_we[0], stalled ? "R8 we" : {tag, " we"}, 32'(mem_we_o), 32'(q_we[0]));
      if (q_we[0])
        chk(mem_wdata_o === q_data[0], stalled ? "R8 wdata" : "R1 wdata", mem_wdata_o, q_data[0]);
      if (mem_ready_i) begin
        n_acc++;
        if (!q_we[0] && q_idx[0] < 8) begin
          chk(rf_we_o === 1'b1 && rf_waddr_o === 4'(q_idx[0]), "R10 rf index",
              {27'd0, rf_we_o, rf_waddr_o}, {27'd0, 1'b1, 4'(q_idx[0])});
          chk(rf_wdata_o === q_data[0], "R10 rf data", rf_wdata_o, q_data[0]);
          regs[q_idx[0]] = q_data[0];
        end else begin
          chk(rf_we_o === 1'b0, "R10 no rf write", 32'(rf_we_o), 0);
        end
        void'(q_addr.pop_front()); void'(q_we.pop_front());
        void'(q_data.pop_front()); void'(q_idx.pop_front());
      end else begin
        chk(rf_we_o === 1'b0, "R10 no rf write while stalled", 32'(rf_we_o), 0);
      end
      stalled = !mem_ready_i;
      @(negedge clk);
      cyc++;
      if (cyc > 400) begin
        chk(1'b0, "R9 operation timeout", cyc, 400);
        break;
      end
    end
    @(negedge clk);
    mem_ready_i = 1'b0;
    #1;
    chk(done_o === 1'b0, "R9 single-cycle done", 32'(done_o), 0);
    chk(mem_req_o === 1'b0, "R9 idle after done", 32'(mem_req_o), 0);
  endtask

  initial begin
    #750000;
    n_err++;
    $display("FAIL watchdog expired at %0t", $time);
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = 32'h1000_0000 + 32'(i) * 32'h0101_0101;
    repeat (3) @(negedge clk);
    #1;
    // R11 reset state
    chk(mem_req_o === 1'b0 && done_o === 1'b0 && rf_we_o === 1'b0 && branch_o === 1'b0,
        "R11 reset outputs", {28'd0, mem_req_o, done_o, rf_we_o, branch_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(mem_req_o === 1'b0 && done_o === 1'b0, "R11 idle after reset",
        {30'd0, mem_req_o, done_o}, 0);

    run_op(1'b0, 8'h81, 1'b0, 32'h2000_0100, 32'h0000_0400, 1'b0); // R1 sparse store
    run_op(1'b0, 8'hFF, 1'b1, 32'h2000_0100, 32'h0000_0410, 1'b0); // R1 full store with link
    run_op(1'b1, 8'h81, 1'b0, 32'h2000_0200, 32'h0000_0420, 1'b0); // R2 sparse load
    run_op(1'b1, 8'hFF, 1'b1, 32'h2000_0300, 32'h0000_0430, 1'b0); // R4 full load with PC
    run_op(1'b1, 8'h00, 1'b1, 32'h2000_0400, 32'h0000_0440, 1'b0); // R4 PC only
    run_op(1'b0, 8'h00, 1'b1, 32'h2000_0500, 32'h0000_0450, 1'b0); // R1 link only
    run_op(1'b0, 8'h00, 1'b0, 32'h2000_0600, 32'h0000_0460, 1'b0); // R7 empty store
    run_op(1'b1, 8'h00, 1'b0, 32'h2000_0700, 32'h0000_0470, 1'b0); // R7 empty load
    run_op(1'b0, 8'h5A, 1'b1, 32'h2000_0800, 32'h0000_0480, 1'b1); // R8 store with stalls
    run_op(1'b1, 8'hA5, 1'b1, 32'h2000_0900, 32'h0000_0490, 1'b1); // R8 load with stalls
    run_op(1'b1, 8'h3C, 1'b0, 32'h2000_0A00, 32'h0000_04A0, 1'b1); // R5 load without PC
    run_op(1'b0, 8'h10, 1'b0, 32'h0000_0002, 32'h0000_04B0, 1'b1); // R3 pointer wrap
    summary();
    $finish;
  end
endmodule